// File: doc/BRIEF.md
# Dual-Bank Interrupt Controller

This block gathers 32 interrupt lines and turns them into two processor requests: a normal request and a fast request. Each request has its own bank of registers, and both banks look at the same 32 input lines. In each bank, software picks for every line whether the line is level-sensitive or edge-latched, and which polarity or edge counts as active. Software also enables or blocks each line, and acknowledges a latched edge by writing a one to the line's bit.

Both banks have the same six-word layout. The fast bank sits 0x20 bytes above the normal bank. Software reads two views of each bank: the pending value before masking, and the pending value after masking. The bank's request output is high while any masked pending bit is set. The bus is a 32-bit synchronous word interface. A write takes effect at the clock edge where it is presented. Read data is registered.

Top module: `intc_dual_bank`

## Requirements
- R1: After reset every register of both banks reads zero (all lines blocked, all lines in level mode), and `irq_req` and `fiq_req` are low.
- R2: Byte offsets within a bank, selected by address bits [4:2]: 0x00 pending view, 0x04 enable, 0x08 acknowledge, 0x0C mode, 0x10 polarity, 0x14 masked view. Address bit 5 selects the normal bank (0) or the fast bank (1). Address bits [1:0] are ignored. The enable, mode and polarity words read back the last value written to them.
- R3: An enable bit of 1 lets its line reach the bank request. An enable bit of 0 keeps the line out of the masked view and out of the request, but the line still shows in the pending view.
- R4: Writing a word to the acknowledge offset clears the edge latch of every line whose bit is 1 in that word. Bits written as 0 leave their latches unchanged.
- R5: A mode bit of 1 makes its line edge-latched and a mode bit of 0 makes it level-sensitive. A line that has just been switched to edge mode has no pending latch until an active edge arrives.
- R6: In edge mode a polarity bit of 1 latches on a rising edge of the synchronized input and 0 latches on a falling edge. The latch then holds until it is acknowledged.
- R7: When an active edge and an acknowledge of the same line fall in the same cycle, the latch stays set.
- R8: In level mode a polarity bit of 1 makes the line active-high and 0 makes it active-low. The pending bit follows the synchronized input, and an acknowledge write does not change it.
- R9: The masked view equals the pending view AND the enable word. A bank's request is the OR of its masked view.
- R10: Each line passes through a two-flop synchronizer. An input change presented before clock edge k changes a level-mode request after edge k+1, and sets an edge latch and its request after edge k+2.
- R11: Reads of the acknowledge offset, of reserved offsets 0x18/0x1C/0x38/0x3C, and of any address at or above 0x40 return zero. Writes to the pending and masked views are ignored.
- R12: A read presented at clock edge k returns its data on `cpu_rdata` after edge k. `cpu_rdata` holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_lines | input | 32 | Asynchronous interrupt inputs, one per line |
| cpu_wr | input | 1 | Write strobe, one word per cycle |
| cpu_rd | input | 1 | Read strobe |
| cpu_addr | input | ADDR_W (8) | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Registered read data |
| irq_req | output | 1 | Normal-bank request |
| fiq_req | output | 1 | Fast-bank request |

## Verification
A wrong internal state shows at the ports within a few cycles. A stuck or missed edge latch shows as a wrong request level two clock edges after the input edge. It also shows as a wrong bit in the pending view on the next read. A wrong enable, mode or polarity word shows on readback at once. A wrong value in any of these words changes a request within two edges of the input it should gate. The bench keeps a behavioural model of both banks and the synchronizer. It compares both requests on every clock and every read word on the cycle after the read. As a result, a divergence is reported in the cycle it first becomes visible.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int INTC_W    = 32;
    localparam int NUM_BANKS = 2;

    typedef logic [INTC_W-1:0] word_t;

    // word slot within one bank window (byte offset / 4)
    typedef enum logic [2:0] {
        SLOT_SRC  = 3'd0,
        SLOT_MASK = 3'd1,
        SLOT_CLR  = 3'd2,
        SLOT_MODE = 3'd3,
        SLOT_LVL  = 3'd4,
        SLOT_STAT = 3'd5,
        SLOT_RSV6 = 3'd6,
        SLOT_RSV7 = 3'd7
    } slot_e;

    typedef struct packed {
        logic  hit;
        logic  bank;
        slot_e slot;
    } dec_t;

    typedef struct packed {
        logic  mask_we;
        logic  mode_we;
        logic  lvl_we;
        word_t wdata;
        word_t clr_bits;
    } bank_cmd_t;

    typedef struct packed {
        word_t src;
        word_t mask;
        word_t mode;
        word_t lvl;
        word_t stat;
    } bank_view_t;

    // low: byte offset inside the 64-byte window, upper_zero: no bits above it
    function automatic dec_t decode_addr(input logic [5:0] low, input logic upper_zero);
        dec_t d;
        d.bank = low[5];
        d.slot = slot_e'(low[4:2]);
        d.hit  = upper_zero && (low[4:2] <= 3'd5);
        return d;
    endfunction

    function automatic word_t pick_view(input bank_view_t v, input slot_e s);
        word_t r;
        case (s)
            SLOT_SRC:  r = v.src;
            SLOT_MASK: r = v.mask;
            SLOT_MODE: r = v.mode;
            SLOT_LVL:  r = v.lvl;
            SLOT_STAT: r = v.stat;
            default:   r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/intc_sync.sv
module intc_sync
    import intc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  word_t din,
    output word_t cur,
    output word_t prev
);

    word_t stage_q [STAGES];
    word_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
            prev_q <= '0;
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
            prev_q <= stage_q[STAGES-1];
        end
    end

    assign cur  = stage_q[STAGES-1];
    assign prev = prev_q;

endmodule

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  word_t      sync_cur,
    input  word_t      sync_prev,
    input  bank_cmd_t  cmd,
    output bank_view_t view,
    output logic       req
);

    word_t mask_q, mode_q, lvl_q, latch_q;
    word_t rise, fall, edge_hit, level_pend, pend;

    always_comb begin
        rise       = sync_cur & ~sync_prev;
        fall       = ~sync_cur & sync_prev;
        edge_hit   = mode_q & ((lvl_q & rise) | (~lvl_q & fall));
        level_pend = ~(sync_cur ^ lvl_q);
        pend       = (mode_q & latch_q) | (~mode_q & level_pend);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            mode_q  <= '0;
            lvl_q   <= '0;
            latch_q <= '0;
        end else begin
            latch_q <= mode_q & (edge_hit | (latch_q & ~cmd.clr_bits));
            if (cmd.mask_we) mask_q <= cmd.wdata;
            if (cmd.mode_we) mode_q <= cmd.wdata;
            if (cmd.lvl_we)  lvl_q  <= cmd.wdata;
        end
    end

    always_comb begin
        view.src  = pend;
        view.mask = mask_q;
        view.mode = mode_q;
        view.lvl  = lvl_q;
        view.stat = pend & mask_q;
        req       = |view.stat;
    end

    // R7: a detected edge always leaves its latch set, acknowledge or not
    a_r7_edge_wins: assert property (@(posedge clk) disable iff (rst)
        (|edge_hit) |=> ((latch_q & $past(edge_hit)) == $past(edge_hit)));

    // R4: latched bits not named by the acknowledge word survive
    a_r4_unnamed_bits_hold: assert property (@(posedge clk) disable iff (rst)
        (|(latch_q & ~cmd.clr_bits & mode_q))
        |=> ((latch_q & $past(latch_q & ~cmd.clr_bits & mode_q))
             == $past(latch_q & ~cmd.clr_bits & mode_q)));

    // R8: lines in level mode never keep an edge latch
    a_r8_level_no_latch: assert property (@(posedge clk) disable iff (rst)
        (|(~mode_q)) |=> ((latch_q & $past(~mode_q)) == '0));

    // R3: with every line blocked the request is quiet
    a_r3_blocked_quiet: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !req);

endmodule

// File: rtl/intc_dual_bank.sv
module intc_dual_bank
    import intc_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [INTC_W-1:0] int_lines,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [INTC_W-1:0] cpu_wdata,
    output logic [INTC_W-1:0] cpu_rdata,
    output logic              irq_req,
    output logic              fiq_req
);

    localparam int WIN_BITS = 6;

    dec_t                 dec;
    word_t                sync_cur, sync_prev;
    bank_view_t           views [NUM_BANKS];
    logic [NUM_BANKS-1:0] reqs;
    word_t                rdata_q;

    always_comb dec = decode_addr(cpu_addr[WIN_BITS-1:0], (cpu_addr >> WIN_BITS) == '0);

    intc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (int_lines),
        .cur  (sync_cur),
        .prev (sync_prev)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_cmd_t cmd;
        logic      sel;

        always_comb begin
            sel          = cpu_wr && dec.hit && (int'(dec.bank) == b);
            cmd.mask_we  = sel && (dec.slot == SLOT_MASK);
            cmd.mode_we  = sel && (dec.slot == SLOT_MODE);
            cmd.lvl_we   = sel && (dec.slot == SLOT_LVL);
            cmd.wdata    = cpu_wdata;
            cmd.clr_bits = (sel && (dec.slot == SLOT_CLR)) ? cpu_wdata : '0;
        end

        intc_bank u_bank (
            .clk       (clk),
            .rst       (rst),
            .sync_cur  (sync_cur),
            .sync_prev (sync_prev),
            .cmd       (cmd),
            .view      (views[b]),
            .req       (reqs[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (cpu_rd) begin
            rdata_q <= dec.hit ? pick_view(views[dec.bank], dec.slot) : '0;
        end
    end

    assign cpu_rdata = rdata_q;
    assign irq_req   = reqs[0];
    assign fiq_req   = reqs[1];

    // R11: acknowledge offset reads as zero
    a_r11_clear_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && dec.hit && dec.slot == SLOT_CLR) |=> (cpu_rdata == '0));

    // R11: unmapped addresses read as zero
    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && !dec.hit) |=> (cpu_rdata == '0));

    // R12: data holds between reads
    a_r12_rdata_holds: assert property (@(posedge clk) disable iff (rst)
        (!cpu_rd) |=> $stable(cpu_rdata));

endmodule

// File: tb/tb_intc_dual_bank.sv
module tb_intc_dual_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] int_lines = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        irq_req, fiq_req;

    always #10 clk = ~clk;   // 50 MHz

    intc_dual_bank dut (
        .clk(clk), .rst(rst), .int_lines(int_lines),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .irq_req(irq_req), .fiq_req(fiq_req)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    string phase    = "R1";
    bit    done     = 0;

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_mask [2], m_mode [2], m_lvl [2], m_latch [2];
    logic [31:0] s1, s2, sp;
    logic [31:0] exp_rdata;
    bit          rd_pend;

    function automatic logic [31:0] m_pend(int b);
        logic [31:0] p;
        for (int i = 0; i < 32; i++)
            p[i] = m_mode[b][i] ? m_latch[b][i] : (m_lvl[b][i] ? s2[i] : !s2[i]);
        return p;
    endfunction

    function automatic logic [31:0] m_read(int off);
        int b, r;
        if (off >= 64) return '0;
        b = off / 32;
        r = (off % 32) / 4;
        case (r)
            0: return m_pend(b);
            1: return m_mask[b];
            3: return m_mode[b];
            4: return m_lvl[b];
            5: return m_pend(b) & m_mask[b];
            default: return '0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < 2; b++) begin
                m_mask[b] = '0; m_mode[b] = '0; m_lvl[b] = '0; m_latch[b] = '0;
            end
            s1 = '0; s2 = '0; sp = '0; rd_pend = 0; exp_rdata = '0;
        end else begin
            int off, wb, wr_r;
            off  = int'(cpu_addr);
            wb   = (off % 64) / 32;
            wr_r = (off % 32) / 4;
            rd_pend = cpu_rd;
            if (cpu_rd) exp_rdata = m_read(off);
            for (int b = 0; b < 2; b++) begin
                for (int i = 0; i < 32; i++) begin
                    bit hit, clr;
                    if (m_mode[b][i]) begin
                        hit = m_lvl[b][i] ? (s2[i] && !sp[i]) : (!s2[i] && sp[i]);
                        clr = cpu_wr && off < 64 && wb == b && wr_r == 2 && cpu_wdata[i];
                        m_latch[b][i] = hit || (m_latch[b][i] && !clr);
                    end else begin
                        m_latch[b][i] = 1'b0;
                    end
                end
            end
            if (cpu_wr && off < 64) begin
                if (wr_r == 1) m_mask[wb] = cpu_wdata;
                if (wr_r == 3) m_mode[wb] = cpu_wdata;
                if (wr_r == 4) m_lvl[wb]  = cpu_wdata;
            end
            sp = s2; s2 = s1; s1 = int_lines;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(phase, {31'd0, irq_req}, {31'd0, |(m_pend(0) & m_mask[0])}, "irq_req vs model (R9)");
            check(phase, {31'd0, fiq_req}, {31'd0, |(m_pend(1) & m_mask[1])}, "fiq_req vs model (R9)");
            if (rd_pend) check(phase, cpu_rdata, exp_rdata, "read data vs model (R12)");
        end
    end

    // ---------------- bus tasks (called at a falling edge) ----------------
    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] d);
        cpu_rd = 1'b1; cpu_addr = a;
        @(negedge clk);
        cpu_rd = 1'b0;
        d = cpu_rdata;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        idle(3);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        phase = "R1";
        check("R1", {30'd0, fiq_req, irq_req}, 32'd0, "requests after reset");
        bus_read(8'h04, d); check("R1", d, 32'h0, "irq enable after reset");
        bus_read(8'h24, d); check("R1", d, 32'h0, "fiq enable after reset");
        bus_read(8'h0C, d); check("R1", d, 32'h0, "irq mode after reset");

        // R2: readback and bank offset
        phase = "R2";
        bus_write(8'h24, 32'hA5A5_0F0F);
        bus_write(8'h30, 32'h1234_5678);
        bus_read(8'h24, d); check("R2", d, 32'hA5A5_0F0F, "fiq enable readback");
        bus_read(8'h30, d); check("R2", d, 32'h1234_5678, "fiq polarity readback");
        bus_read(8'h04, d); check("R2", d, 32'h0, "irq enable untouched by fiq write");
        bus_write(8'h24, 32'h0);
        bus_write(8'h30, 32'h0);
        bus_write(8'h05, 32'h0000_0078);   // low address bits ignored: enable 3..6
        bus_read(8'h04, d); check("R2", d, 32'h0000_0078, "irq enable via unaligned address");
        bus_write(8'h0C, 32'h0000_0070);   // edge mode on lines 4,5,6
        bus_write(8'h10, 32'h0000_0038);   // active high / rising on 3,4,5
        idle(3);

        // R10: synchronizer latency, level then edge
        phase = "R10";
        check("R10", {31'd0, irq_req}, 32'd0, "request idle before stimulus");
        int_lines[3] = 1'b1;
        @(negedge clk); check("R10", {31'd0, irq_req}, 32'd0, "level: after first edge");
        @(negedge clk); check("R10", {31'd0, irq_req}, 32'd1, "level: after second edge");
        int_lines[3] = 1'b0;
        idle(4);
        int_lines[4] = 1'b1;
        @(negedge clk); check("R10", {31'd0, irq_req}, 32'd0, "edge: after first edge");
        @(negedge clk); check("R10", {31'd0, irq_req}, 32'd0, "edge: after second edge");
        @(negedge clk); check("R10", {31'd0, irq_req}, 32'd1, "edge: after third edge");

        // R6: latch holds after input returns
        phase = "R6";
        int_lines[4] = 1'b0;
        idle(4);
        bus_read(8'h00, d); check("R6", d & 32'h10, 32'h10, "rising latch holds");
        int_lines[6] = 1'b1;
        idle(4);
        bus_read(8'h00, d); check("R6", d & 32'h40, 32'h0, "falling line: rising edge ignored");
        int_lines[6] = 1'b0;
        idle(4);
        bus_read(8'h00, d); check("R6", d & 32'h40, 32'h40, "falling edge latched");

        // R4: acknowledge is write-one-to-clear
        phase = "R4";
        bus_write(8'h08, 32'hFFFF_FFAF);   // all but bits 4 and 6
        bus_read(8'h00, d); check("R4", d & 32'h50, 32'h50, "zero bits leave latches");
        bus_write(8'h08, 32'h0000_0050);
        bus_read(8'h00, d); check("R4", d & 32'h50, 32'h0, "one bits clear latches");

        // R7: edge and acknowledge in the same cycle
        phase = "R7";
        int_lines[5] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_write(8'h08, 32'h0000_0020);   // lands on the edge that sets the latch
        bus_read(8'h00, d); check("R7", d & 32'h20, 32'h20, "edge beats acknowledge");
        bus_write(8'h08, 32'h0000_0020);
        bus_read(8'h00, d); check("R7", d & 32'h20, 32'h0, "later acknowledge clears");
        int_lines[5] = 1'b0;
        idle(3);

        // R8: level polarity, acknowledge has no effect
        phase = "R8";
        int_lines[3] = 1'b1;
        idle(3);
        bus_write(8'h08, 32'h0000_0008);
        bus_read(8'h00, d); check("R8", d & 32'h8, 32'h8, "acknowledge ignored on level line");
        bus_read(8'h00, d); check("R8", d & 32'h1, 32'h1, "active-low line with input low pending");
        int_lines[0] = 1'b1;
        idle(3);
        bus_read(8'h00, d); check("R8", d & 32'h1, 32'h0, "active-low line with input high idle");

        // R3: masking
        phase = "R3";
        bus_write(8'h04, 32'h0);
        @(negedge clk);
        check("R3", {31'd0, irq_req}, 32'd0, "blocked line gives no request");
        bus_read(8'h14, d); check("R3", d, 32'h0, "masked view empty");
        bus_read(8'h00, d); check("R3", d & 32'h8, 32'h8, "pending view still shows line");

        // R5: switching a level line to edge mode
        phase = "R5";
        bus_write(8'h0C, 32'h0000_0078);
        bus_read(8'h00, d); check("R5", d & 32'h8, 32'h0, "fresh edge line has no latch");
        bus_write(8'h0C, 32'h0000_0070);
        bus_read(8'h00, d); check("R5", d & 32'h8, 32'h8, "back to level follows input");

        // R9: fast bank request and status view
        phase = "R9";
        bus_write(8'h30, 32'h0000_0080);
        bus_write(8'h24, 32'h0000_0080);
        int_lines[7] = 1'b1;
        idle(3);
        check("R9", {30'd0, fiq_req, irq_req}, 32'd2, "fast request only");
        bus_read(8'h34, d); check("R9", d, 32'h0000_0080, "fast masked view");

        // R11: read-only and unmapped
        phase = "R11";
        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_write(8'h34, 32'hFFFF_FFFF);
        bus_read(8'h34, d); check("R11", d, 32'h0000_0080, "write to masked view ignored");
        bus_read(8'h28, d); check("R11", d, 32'h0, "acknowledge reads zero");
        bus_read(8'h1C, d); check("R11", d, 32'h0, "reserved offset reads zero");
        bus_write(8'h44, 32'hFFFF_FFFF);
        bus_read(8'h44, d); check("R11", d, 32'h0, "unmapped reads zero");
        bus_read(8'h04, d); check("R11", d, 32'h0, "unmapped write did not alias");

        // R12: read data holds without a read
        phase = "R12";
        bus_read(8'h30, d);
        idle(3);
        check("R12", cpu_rdata, 32'h0000_0080, "read data holds");

        // random traffic checked against the model
        phase = "R9";
        for (int n = 0; n < 3000; n++) begin
            int op;
            logic [7:0] a;
            if ($urandom_range(0, 3) == 0) int_lines = int_lines ^ (32'h1 << $urandom_range(0, 31));
            op = $urandom_range(0, 5);
            a  = 8'($urandom_range(0, 17) * 4);
            if (op == 0) begin
                cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = $urandom();
            end else if (op == 1) begin
                cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = $urandom() & $urandom();
            end else if (op < 4) begin
                cpu_rd = 1'b1; cpu_addr = a;
            end
            @(negedge clk);
            cpu_wr = 1'b0; cpu_rd = 1'b0;
        end

        idle(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule